// File: doc/BRIEF.md
# Mode-3 SPI Master Shifter

This block is a serial peripheral master that moves one byte in each direction per transfer. A single 8-bit shift register holds the outgoing byte. The incoming bits enter at the low end of the same register as the outgoing bits leave at the top, so a transfer always sends something. A transfer that only reads must still supply a filler byte.

The serial clock comes from a counter on the system clock and runs only while a transfer is in progress. It rests high. The outgoing line changes on the clock's falling edges, and the incoming line is captured on its rising edges. Each attached slave has its own active-low select line. The select, clock and data lines share the same timing.

To start a transfer, the host puts a byte on `tx_byte` and a slave number on `slv_sel`, then raises `start` for one cycle. `busy` stays high while the transfer runs. When it ends, `done` pulses for one cycle and `rx_byte` holds the byte received from the slave.

Top module: `spi_mode3_master`

## Requirements
- R1: During and after a synchronous reset, `sclk` is 1, every `cs_n` bit is 1, `busy` is 0, `done` is 0 and `rx_byte` is 0.
- R2: A `start` seen while idle begins a transfer. For its whole duration the `cs_n` bit whose index equals `slv_sel` is 0 and all other bits are 1.
- R3: `sclk` is 1 whenever no transfer runs. Each transfer produces exactly 8 falling and 8 rising `sclk` edges, and the first edge is a falling one.
- R4: Every `sclk` level lasts exactly HALF_DIV system cycles. Select goes low HALF_DIV cycles before the first falling edge and goes high HALF_DIV cycles after the eighth rising edge.
- R5: `mosi` carries `tx_byte` most significant bit first. It is set when the transfer is accepted and changes only on falling `sclk` edges.
- R6: `miso` is captured on each rising `sclk` edge, most significant bit first. The eight captured bits form `rx_byte`.
- R7: `done` is high for exactly one cycle, 17*HALF_DIV cycles after the clock edge that accepts `start`. `rx_byte` is valid in that cycle and holds its value until the next `done`.
- R8: `start` is ignored while `busy` is 1. The running transfer keeps its byte and its slave, and no second transfer follows.
- R9: A `slv_sel` value of NUM_SLV or more runs a full transfer with every `cs_n` bit held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_byte | input | 8 | Byte to send, sampled with `start` |
| slv_sel | input | SEL_W | Index of the slave to address, sampled with `start` |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle strobe at the end of a transfer |
| rx_byte | output | 8 | Byte received in the last transfer |
| sclk | output | 1 | Serial clock, rests high |
| mosi | output | 1 | Serial data out to the slaves |
| miso | input | 1 | Serial data in from the addressed slave |
| cs_n | output | NUM_SLV | Per-slave select lines, active low |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the middle of a running transfer with different data and a different slave number. The bench raises `start` twenty cycles into a transfer with the byte inverted and the index moved on by one. It then confirms that the behavioural slave still receives the first byte and that the original select line is the only one driven low. It also watches `sclk` for twenty cycles after `done` to confirm that no further edges appear. A second case that needs deliberate stimulus is an index beyond the last slave: the bench counts the clock edges of that transfer and confirms that no select line is ever driven low.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int unsigned WORD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } spim_state_e;

    typedef struct packed {
        logic load;
        logic sample;
        logic shift;
    } shop_t;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    import spim_pkg::*;

    localparam int unsigned CW = width_of(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/spim_shreg.sv
module spim_shreg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  spim_pkg::shop_t op,
    input  logic [W-1:0] load_val,
    input  logic         miso,
    output logic         msb,
    output logic [W-1:0] next_word
);
    logic [W-1:0] sr;
    logic         samp;

    assign msb       = sr[W-1];
    assign next_word = {sr[W-2:0], samp};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            samp <= 1'b0;
        end else begin
            if (op.load) begin
                sr <= load_val;
            end else if (op.shift) begin
                sr <= next_word;
            end
            if (op.sample) begin
                samp <= miso;
            end
        end
    end

    p_one_op_r5: assert property (@(posedge clk) disable iff (rst)
        $countones({op.load, op.sample, op.shift}) <= 1);

endmodule

// File: rtl/spim_cs_dec.sv
module spim_cs_dec #(
    parameter int unsigned NUM_SLV = 3,
    parameter int unsigned SEL_W   = 2
) (
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_SLV-1:0] cs_n
);
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_line
        assign cs_n[i] = !(en && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/spi_mode3_master.sv
module spi_mode3_master #(
    parameter int unsigned NUM_SLV  = 3,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned HALF_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [7:0]         tx_byte,
    input  logic [SEL_W-1:0]   slv_sel,
    output logic               busy,
    output logic               done,
    output logic [7:0]         rx_byte,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_SLV-1:0] cs_n
);
    import spim_pkg::*;

    localparam int unsigned BCW = width_of(WORD_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_W - 1);

    spim_state_e        state;
    logic               sck_q;
    logic [BCW-1:0]     bcnt;
    logic [SEL_W-1:0]   sel_q;
    logic               done_q;
    logic [WORD_W-1:0]  rx_q;
    logic               tick;
    logic               finish;
    shop_t              op;
    logic [WORD_W-1:0]  next_word;

    assign busy   = (state != ST_IDLE);
    assign done   = done_q;
    assign rx_byte = rx_q;
    assign sclk   = sck_q;
    assign finish = (state == ST_SHIFT) && tick && sck_q && (bcnt == LAST_BIT);

    always_comb begin
        op        = '0;
        op.load   = (state == ST_IDLE) && start;
        op.sample = (state == ST_SHIFT) && tick && !sck_q;
        op.shift  = (state == ST_SHIFT) && tick && sck_q;
    end

    spim_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    spim_shreg #(.W(WORD_W)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_val  (tx_byte),
        .miso      (miso),
        .msb       (mosi),
        .next_word (next_word)
    );

    spim_cs_dec #(.NUM_SLV(NUM_SLV), .SEL_W(SEL_W)) u_cs (
        .en   (busy),
        .sel  (sel_q),
        .cs_n (cs_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sck_q  <= 1'b1;
            bcnt   <= '0;
            sel_q  <= '0;
            done_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sck_q <= 1'b1;
                    if (start) begin
                        sel_q <= slv_sel;
                        state <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sck_q <= 1'b0;
                        bcnt  <= '0;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else if (finish) begin
                            rx_q   <= next_word;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            sck_q <= 1'b0;
                            bcnt  <= bcnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checking logic: cycles since the last clock or select change
    logic        sck_prev;
    logic        busy_prev;
    int unsigned gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev  <= 1'b1;
            busy_prev <= 1'b0;
            gap       <= 0;
        end else begin
            sck_prev  <= sck_q;
            busy_prev <= busy;
            if ((sck_q != sck_prev) || (busy != busy_prev)) begin
                gap <= 1;
            end else if (gap < HALF_DIV + 2) begin
                gap <= gap + 1;
            end
        end
    end

    p_sck_half_r4: assert property (@(posedge clk) disable iff (rst)
        (sck_q != sck_prev) |-> (gap == HALF_DIV));

    p_cs_trail_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_prev && !busy) |-> (gap == HALF_DIV));

    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sclk);

    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_mosi_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cs_n));

endmodule

// File: tb/spi_mode3_master_bench.sv
module spi_mode3_master_bench;

    localparam int NUM_SLV  = 3;
    localparam int SEL_W    = 2;
    localparam int HALF_DIV = 4;
    localparam int NVEC     = 6;

    // {tx byte, slave index, byte the slave returns}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'hA5, 2'd0, 8'h3C},
        {8'h00, 2'd1, 8'hFF},
        {8'hFF, 2'd2, 8'h00},
        {8'h81, 2'd0, 8'h7E},
        {8'hFF, 2'd1, 8'hC9},
        {8'h5A, 2'd3, 8'h96}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [7:0]         tx_byte = '0;
    logic [SEL_W-1:0]   slv_sel = '0;
    logic               busy;
    logic               done;
    logic [7:0]         rx_byte;
    logic               sclk;
    logic               mosi;
    logic               miso = 1'b1;
    logic [NUM_SLV-1:0] cs_n;

    int checks = 0;
    int errors = 0;

    logic [7:0]         s_reg;
    logic [7:0]         s_got;
    int                 rises;
    int                 falls;
    logic [NUM_SLV-1:0] exp_cs;
    bit                 cs_bad;

    always #5 clk = ~clk;

    spi_mode3_master #(
        .NUM_SLV(NUM_SLV), .SEL_W(SEL_W), .HALF_DIV(HALF_DIV)
    ) u_spi_mode3_master (
        .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte),
        .slv_sel(slv_sel), .busy(busy), .done(done), .rx_byte(rx_byte),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural slave: shifts out on falling edges, captures on rising edges
    initial begin
        forever begin
            @(posedge sclk);
            s_got = {s_got[6:0], mosi};
            rises++;
            if (cs_n !== exp_cs) cs_bad = 1'b1;
        end
    end

    initial begin
        forever begin
            @(negedge sclk);
            falls++;
            if (falls > 1) begin
                s_reg = {s_reg[6:0], 1'b0};
                miso  = s_reg[7];
            end
        end
    end

    task automatic run_xfer(input logic [7:0] tx, input logic [1:0] sel,
                            input logic [7:0] sb, input bit poke);
        int cyc;
        s_reg  = sb;
        miso   = sb[7];
        rises  = 0;
        falls  = 0;
        s_got  = '0;
        cs_bad = 1'b0;
        exp_cs = (sel < NUM_SLV) ? ~(NUM_SLV'(1) << sel) : '1;
        @(negedge clk);
        tx_byte = tx;
        slv_sel = sel;
        start   = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cyc = 0;
        while (!done && cyc < 1000) begin
            @(posedge clk);
            #1;
            cyc++;
            if (poke && cyc == 20) begin
                start   = 1'b1;
                tx_byte = ~tx;
                slv_sel = sel + 2'd1;
            end else begin
                start = 1'b0;
            end
        end
        check("R7 done latency", cyc, 17 * HALF_DIV);
        check("R6 rx_byte", rx_byte, sb);
        check("R5 slave received", s_got, tx);
        check("R3 rising edges", rises, 8);
        check("R3 falling edges", falls, 8);
        check(sel < NUM_SLV ? "R2 select line" : "R9 no select", cs_bad, 0);
        check("R4 select released at done", cs_n, {NUM_SLV{1'b1}});
        @(posedge clk);
        #1;
        check("R7 done single cycle", done, 0);
        check("R7 rx held", rx_byte, sb);
        repeat (20) @(posedge clk);
        #1;
        check(poke ? "R8 no second transfer" : "R3 idle clock", {busy, sclk, 30'(rises)}, {1'b0, 1'b1, 30'd8});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 sclk reset", sclk, 1);
        check("R1 cs_n reset", cs_n, {NUM_SLV{1'b1}});
        check("R1 busy/done reset", {busy, done}, 0);
        check("R1 rx reset", rx_byte, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            run_xfer(VEC[i][17:10], VEC[i][9:8], VEC[i][7:0], 1'b0);
        end

        // R8: start pulsed in the middle of a transfer
        run_xfer(8'hC3, 2'd1, 8'h5E, 1'b1);

        // R1: reset in the middle of a transfer returns to the idle state
        @(negedge clk);
        tx_byte = 8'h11;
        slv_sel = 2'd2;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset", {busy, done, sclk, 8'(rx_byte), 3'(cs_n)}, {1'b0, 1'b0, 1'b1, 8'h00, 3'b111});
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule